// File: doc/BRIEF.md
# Indexed clock-register and paged RAM host port

This block sits between an asynchronous strobe-driven host bus and the storage of a real-time-clock subsystem. The host sees two small address spaces, each picked by its own active-low select. In the clock space, address bit 0 chooses between an index register and a data port. The data port reaches whichever of 64 byte-wide registers the index names. In the RAM space, address bit 5 chooses between a page register and a 32-byte window. The window is placed inside a 4096-byte store by the page register.

The strobes and selects are not tied to the system clock. The write strobe is brought into the clock domain through two flip-flops. Address, data and target are captured while the strobe is low, and the write is committed on the strobe's rising edge. Reads are a combinational path from the pins, gated by an output-enable. A standby input blocks all access and cancels a write that is in flight. A host-reset input closes the clock space and leaves the RAM space usable.

Top module: `rtc_xram_bus`

## Requirements
- R1: A write takes effect only after the write strobe rises at the end of a low pulse, with a select held low during the pulse. While the strobe is still low, a read of the target returns its old value.
- R2: `rdata_oe` is high only while `rd_n` is low, `stby_n` is high and a space is reachable. Whenever `rdata_oe` is low, `rdata` is 0.
- R3: In the clock space with addr[0]=0, the index register is read and written. It keeps data bits 5:0, and bits 7:6 read as 0.
- R4: In the clock space with addr[0]=1, the data port reads and writes register number `index`, for any of the 64 index values (14 to 63 are general storage).
- R5: In the RAM space with addr[5]=1, the 7-bit page register is reached whatever addr[4:0] holds. Bit 7 reads as 0.
- R6: In the RAM space with addr[5]=0, the byte at RAM address {page, addr[4:0]} is read or written.
- R7: Registers 12 and 13 ignore writes. They read the `stat_c` and `stat_d` inputs.
- R8: Register 10 stores only bits 6:0 on a write. Bit 7 reads the `uip` input.
- R9: While `stby_n` is low, reads are disabled. A write whose pulse overlaps a low `stby_n` at any time is dropped.
- R10: While `host_reset_n` is low, the clock space is neither readable nor writable. The RAM space still works.
- R11: When both selects are low, the clock space takes the access and the RAM space is not touched.
- R12: After `rst_n`, the index and page registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| host_reset_n | input | 1 | Active-low host reset; closes the clock space |
| stby_n | input | 1 | Active-low standby; inhibits all access |
| rtc_sel_n | input | 1 | Active-low clock-space select |
| xram_sel_n | input | 1 | Active-low RAM-space select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; commits on its rise |
| addr | input | 6 | Host address |
| wdata | input | 8 | Host write data |
| stat_c | input | 8 | Read-only status byte shown at register 12 |
| stat_d | input | 8 | Read-only status byte shown at register 13 |
| uip | input | 1 | Flag shown in bit 7 of register 10 |
| rdata | output | 8 | Read data (0 when not enabled) |
| rdata_oe | output | 1 | Read data output-enable |

## Verification
Random mixes of index, data-port, page and window accesses are checked against a reference model. These show whether the index and the page really steer later accesses, or whether data lands at a fixed place. Directed cases cover the rest:
- all-ones writes to the index and page registers, which expose unmasked upper bits;
- a page write through every alias, which separates address decoding that looks only at bit 5 from one that uses the low bits;
- pages 0 and 127 at offsets 0 and 31, which catch swapped or truncated address composition.

Further cases cover a read taken in the middle of a write pulse, a standby pulse that ends before the strobe rises, both selects low together, and the read-only status bits while their inputs change.

// File: rtl/rtc_xram_bus.sv
module rtc_xram_bus #(
  parameter int DW     = 8,
  parameter int IDX_W  = 6,
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 5,
  parameter int REG_A  = 10,
  parameter int REG_C  = 12,
  parameter int REG_D  = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_reset_n,
  input  logic           stby_n,
  input  logic           rtc_sel_n,
  input  logic           xram_sel_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [OFS_W:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  stat_c,
  input  logic [DW-1:0]  stat_d,
  input  logic           uip,
  output logic [DW-1:0]  rdata,
  output logic           rdata_oe
);

  localparam int NREG  = 1 << IDX_W;
  localparam int RAM_W = PAGE_W + OFS_W;
  localparam int NRAM  = 1 << RAM_W;

  logic [DW-1:0]     regs_q [NREG];
  logic [DW-1:0]     mem_q  [NRAM];
  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;

  logic              wr_m, wr_s, wr_d;
  logic              armed_q, cap_rtc_q, kill_q;
  logic [OFS_W:0]    cap_addr_q;
  logic [DW-1:0]     cap_data_q;

  logic rtc_ok, xram_ok, rise, idle, wr_fire;
  logic [DW-1:0] rd_val;

  // The clock-space select claims the bus whenever it is low.
  assign rtc_ok  = ~rtc_sel_n & host_reset_n;
  assign xram_ok = ~xram_sel_n & rtc_sel_n;

  assign rise    = wr_s & ~wr_d;
  assign idle    = wr_s & wr_d;
  assign wr_fire = rise & armed_q & ~kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_m       <= 1'b1;
      wr_s       <= 1'b1;
      wr_d       <= 1'b1;
      armed_q    <= 1'b0;
      cap_rtc_q  <= 1'b0;
      kill_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      wr_m <= wr_n;
      wr_s <= wr_m;
      wr_d <= wr_s;
      if (!wr_s) begin
        armed_q    <= rtc_ok | xram_ok;
        cap_rtc_q  <= rtc_ok;
        cap_addr_q <= addr;
        cap_data_q <= wdata;
      end
      if (!stby_n)   kill_q <= 1'b1;
      else if (idle) kill_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      page_q <= '0;
    end else if (wr_fire) begin
      if (cap_rtc_q && !cap_addr_q[0])
        idx_q <= cap_data_q[IDX_W-1:0];
      if (!cap_rtc_q && cap_addr_q[OFS_W])
        page_q <= cap_data_q[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && cap_rtc_q && cap_addr_q[0]) begin
      if (int'(idx_q) == REG_A)
        regs_q[idx_q] <= {1'b0, cap_data_q[DW-2:0]};
      else if (int'(idx_q) != REG_C && int'(idx_q) != REG_D)
        regs_q[idx_q] <= cap_data_q;
    end
    if (wr_fire && !cap_rtc_q && !cap_addr_q[OFS_W])
      mem_q[{page_q, cap_addr_q[OFS_W-1:0]}] <= cap_data_q;
  end

  always_comb begin
    rd_val = '0;
    if (rtc_ok) begin
      if (!addr[0])                 rd_val = {{(DW-IDX_W){1'b0}}, idx_q};
      else if (int'(idx_q) == REG_A) rd_val = {uip, regs_q[idx_q][DW-2:0]};
      else if (int'(idx_q) == REG_C) rd_val = stat_c;
      else if (int'(idx_q) == REG_D) rd_val = stat_d;
      else                          rd_val = regs_q[idx_q];
    end else if (xram_ok) begin
      if (addr[OFS_W]) rd_val = {{(DW-PAGE_W){1'b0}}, page_q};
      else             rd_val = mem_q[{page_q, addr[OFS_W-1:0]}];
    end
  end

  assign rdata_oe = ~rd_n & stby_n & (rtc_ok | xram_ok);
  assign rdata    = rdata_oe ? rd_val : '0;

  // R2
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

  // R1
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(idx_q) && $stable(page_q));

  // R9
  stby_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> !wr_fire);

  // R10
  hreset_blocks_rtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_reset_n |=> !(wr_fire && cap_rtc_q));

  // R5
  page_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && rtc_sel_n && !xram_sel_n && addr[OFS_W]) |-> rdata[DW-1:PAGE_W] == '0);

  // R3
  index_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && !rtc_sel_n && !addr[0]) |-> rdata[DW-1:IDX_W] == '0);

endmodule

// File: tb/sim_rtc_xram_bus.sv
module sim_rtc_xram_bus;
  logic clk = 0, rst_n = 0, host_reset_n = 1, stby_n = 1;
  logic rtc_sel_n = 1, xram_sel_n = 1, rd_n = 1, wr_n = 1, uip = 0;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0, stat_c = 8'h5A, stat_d = 8'hC3;
  logic [7:0] rdata;
  logic rdata_oe;

  int vectors = 0, miscompares = 0;
  logic [7:0] ref_reg [64];
  logic [7:0] ref_mem [4096];
  bit         ram_ok  [4096];
  logic [5:0] ref_idx = 0;
  logic [6:0] ref_page = 0;

  always #10 clk = ~clk;

  rtc_xram_bus u0 (.clk(clk), .rst_n(rst_n), .host_reset_n(host_reset_n), .stby_n(stby_n),
    .rtc_sel_n(rtc_sel_n), .xram_sel_n(xram_sel_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .stat_c(stat_c), .stat_d(stat_d), .uip(uip), .rdata(rdata), .rdata_oe(rdata_oe));

  function automatic logic [7:0] exp_reg(input logic [5:0] i);
    if (i == 6'd10) return {uip, ref_reg[i][6:0]};
    if (i == 6'd12) return stat_c;
    if (i == 6'd13) return stat_d;
    return ref_reg[i];
  endfunction

  function automatic logic [7:0] exp_read(input bit rtc, input logic [5:0] a);
    if (rtc) return a[0] ? exp_reg(ref_idx) : {2'b00, ref_idx};
    return a[5] ? {1'b0, ref_page} : ref_mem[{ref_page, a[4:0]}];
  endfunction

  task automatic model_write(input bit rtc, input logic [5:0] a, input logic [7:0] d);
    if (rtc) begin
      if (!a[0]) ref_idx = d[5:0];
      else if (ref_idx == 6'd10) ref_reg[10] = {1'b0, d[6:0]};
      else if (ref_idx != 6'd12 && ref_idx != 6'd13) ref_reg[ref_idx] = d;
    end else begin
      if (a[5]) ref_page = d[6:0];
      else begin
        ref_mem[{ref_page, a[4:0]}] = d;
        ram_ok[{ref_page, a[4:0]}] = 1'b1;
      end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input bit rs, input bit xs, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    rtc_sel_n = ~rs; xram_sel_n = ~xs; addr = a; wdata = d; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (5) @(negedge clk);
    rtc_sel_n = 1; xram_sel_n = 1;
  endtask

  task automatic do_write(input bit rtc, input logic [5:0] a, input logic [7:0] d);
    bus_write(rtc, !rtc, a, d);
    model_write(rtc, a, d);
  endtask

  task automatic bus_read(input bit rs, input bit xs, input logic [5:0] a,
                          output logic [7:0] v, output logic o);
    @(negedge clk);
    rtc_sel_n = ~rs; xram_sel_n = ~xs; addr = a; rd_n = 0;
    #2; v = rdata; o = rdata_oe;
    @(negedge clk);
    rd_n = 1; rtc_sel_n = 1; xram_sel_n = 1;
  endtask

  task automatic read_check(input string tag, input bit rtc, input logic [5:0] a);
    logic [7:0] v; logic o;
    bus_read(rtc, !rtc, a, v, o);
    check(tag, {7'b0, o}, 8'h01);
    check(tag, v, exp_read(rtc, a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] v; logic o;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R12 reset state
    read_check("R12 index after reset", 1, 6'd0);
    read_check("R12 page after reset", 0, 6'h20);

    // R2 no strobe, no enable
    @(negedge clk); rtc_sel_n = 0; addr = 0; #2;
    check("R2 oe without rd_n", {7'b0, rdata_oe}, 8'h00);
    check("R2 rdata without rd_n", rdata, 8'h00);
    @(negedge clk); rtc_sel_n = 1;

    // R4 fill every register through the data port
    for (int i = 0; i < 64; i++) begin
      do_write(1, 6'd0, 8'(i));
      do_write(1, 6'd1, 8'(i * 7 + 3));
    end
    do_write(1, 6'd0, 8'd63); read_check("R4 register 63", 1, 6'd1);
    do_write(1, 6'd0, 8'd14); read_check("R4 register 14", 1, 6'd1);

    // R3 index masking
    do_write(1, 6'd0, 8'hFF);
    read_check("R3 index upper bits", 1, 6'd0);

    // R5 aliases
    do_write(0, 6'h3F, 8'hFF);
    read_check("R5 page via alias 20", 0, 6'h20);
    do_write(0, 6'h2A, 8'h15);
    read_check("R5 page via alias 3F", 0, 6'h3F);

    // R6 window corners
    do_write(0, 6'h20, 8'h7F); do_write(0, 6'h1F, 8'hA5);
    do_write(0, 6'h20, 8'h00); do_write(0, 6'h00, 8'h3C);
    read_check("R6 page 0 offset 0", 0, 6'h00);
    do_write(0, 6'h20, 8'h7F);
    read_check("R6 page 127 offset 31", 0, 6'h1F);

    // R7 read-only status
    do_write(1, 6'd0, 8'd12); do_write(1, 6'd1, 8'h00);
    read_check("R7 register 12", 1, 6'd1);
    stat_c = 8'h81; read_check("R7 register 12 follows input", 1, 6'd1);
    do_write(1, 6'd0, 8'd13); do_write(1, 6'd1, 8'h11);
    read_check("R7 register 13", 1, 6'd1);

    // R8 register 10 bit 7
    do_write(1, 6'd0, 8'd10); do_write(1, 6'd1, 8'hFF);
    uip = 0; read_check("R8 bit7 low", 1, 6'd1);
    uip = 1; read_check("R8 bit7 high", 1, 6'd1);
    uip = 0;

    // R1 read mid-pulse sees old value
    do_write(1, 6'd0, 8'd20); do_write(1, 6'd1, 8'h11);
    @(negedge clk); rtc_sel_n = 0; addr = 6'd1; wdata = 8'h99; wr_n = 0;
    repeat (6) @(negedge clk);
    rd_n = 0; #2;
    check("R1 value before strobe rise", rdata, 8'h11);
    @(negedge clk); rd_n = 1; wr_n = 1;
    repeat (5) @(negedge clk); rtc_sel_n = 1;
    model_write(1, 6'd1, 8'h99);
    read_check("R1 value after strobe rise", 1, 6'd1);

    // R9 standby
    do_write(0, 6'h20, 8'h05); do_write(0, 6'h03, 8'h44);
    stby_n = 0; bus_write(0, 1, 6'h03, 8'hEE); stby_n = 1;
    read_check("R9 write during standby dropped", 0, 6'h03);
    @(negedge clk); xram_sel_n = 0; addr = 6'h03; wr_n = 0; wdata = 8'hDD;
    repeat (2) @(negedge clk); stby_n = 0;
    @(negedge clk); stby_n = 1;
    repeat (2) @(negedge clk); wr_n = 1;
    repeat (5) @(negedge clk); xram_sel_n = 1;
    read_check("R9 terminated write dropped", 0, 6'h03);
    stby_n = 0; bus_read(0, 1, 6'h03, v, o); stby_n = 1;
    check("R9 oe in standby", {7'b0, o}, 8'h00);

    // R10 host reset
    host_reset_n = 0;
    bus_write(1, 0, 6'd1, 8'h77);
    bus_read(1, 0, 6'd1, v, o);
    check("R10 clock-space oe", {7'b0, o}, 8'h00);
    do_write(0, 6'h04, 8'h66);
    read_check("R10 RAM still usable", 0, 6'h04);
    host_reset_n = 1;
    read_check("R10 clock write dropped", 1, 6'd1);

    // R11 both selects
    bus_write(1, 1, 6'd1, 8'h2B); model_write(1, 6'd1, 8'h2B);
    read_check("R11 clock space took write", 1, 6'd1);
    read_check("R11 RAM byte 1 untouched", 0, 6'h01);
    read_check("R11 RAM byte 3 untouched", 0, 6'h03);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op; logic [5:0] a; logic [7:0] d;
      op = int'($urandom % 7); d = 8'($urandom);
      a = 6'($urandom);
      case (op)
        0: do_write(1, 6'd0, d);
        1: do_write(1, 6'd1, d);
        2: read_check("R4 random data port", 1, 6'd1);
        3: do_write(0, {1'b1, a[4:0]}, d);
        4: do_write(0, {1'b0, a[4:0]}, d);
        5: if (ram_ok[{ref_page, a[4:0]}]) read_check("R6 random window", 0, {1'b0, a[4:0]});
        default: begin
          read_check("R3 random index", 1, 6'd0);
          read_check("R5 random page", 0, {1'b1, a[4:0]});
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule